// File: doc/BRIEF.md
# Microcode-Driven 8-bit ALU with Selectable Flag Update

This block is the arithmetic and logic unit of a small microcoded 8-bit processor. Each cycle the microsequencer presents two operand bytes, a 6-bit operation code, the instruction byte and a 2-bit flag-update mode. The unit returns the data result combinationally, in the same cycle. It also holds the five status flags: carry, auxiliary carry, zero, sign and parity. These flags change on the next rising clock edge, as far as the mode allows.

The operations cover binary add and subtract, each with and without an incoming carry or borrow. They also cover four bitwise functions, four rotates, a pass-through of the first operand, generation of the restart vector, and setting or complementing the carry. One control input makes the carry-using operations take the auxiliary carry as their carry input. The microcode uses this for 16-bit increment and decrement sequences.

Top module: `ucode_alu`

## Requirements
- R1: While rst_n is low, all five flags read 0, and they stay 0 until a flag write occurs.
- R2: Code 001100 gives src_b+src_a and code 001101 gives src_b+src_a+carry-in, modulo 256. The new CY is the carry out of bit 7 and the new AC is the carry out of bit 3.
- R3: Code 001110 gives src_b-src_a and code 001111 gives src_b-src_a-borrow-in, modulo 256. The new CY is set when src_a plus the borrow-in exceeds src_b. The new AC is set when the low nibble of src_a plus the borrow-in exceeds the low nibble of src_b.
- R4: Codes 000100, 000101, 000110 and 000111 give src_a AND src_b, src_a OR src_b, NOT src_a and src_a XOR src_b respectively. Each of them makes the new CY and the new AC 0.
- R5: Codes 000000 to 000011 rotate src_a as follows. 000000 rotates left through bit 7. 000001 rotates right through bit 0. 000010 rotates left through CY. 000011 rotates right through CY. In every case the bit shifted out becomes the new CY and AC is kept.
- R6: Code 010111 outputs src_a and code 011111 outputs 8 times instr[5:3]. Both keep CY and AC.
- R7: Code 101100 complements CY and code 101101 sets CY. Both output 0 and keep AC.
- R8: psw_mode bit 0 enables the write of CY, and bit 1 enables the write of AC, Z, S and P. So 00 changes nothing, 01 changes only CY, 10 changes all but CY and 11 changes all five.
- R9: When they are written, Z is 1 exactly when the result is 0, S equals result bit 7, and P is 1 when the result has an even number of ones.
- R10: For codes 001101 and 001111, the carry-in (or borrow-in) is the stored AC when aux_as_carry is 1, and the stored CY when it is 0. The input has no effect on the other codes.
- R11: Any code not listed above outputs 0 and leaves every flag unchanged, whatever psw_mode is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 8 | First operand |
| src_b | input | 8 | Second operand (minuend / augend) |
| alu_op | input | 6 | Operation code |
| instr | input | 8 | Instruction byte; bits 5:3 give the restart number |
| psw_mode | input | 2 | Flag write enables: bit 0 for CY, bit 1 for AC/Z/S/P |
| aux_as_carry | input | 1 | Use stored AC as the carry input of the carry-using ops |
| result | output | 8 | Combinational data result |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_ac | output | 1 | Auxiliary carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even-parity flag |

## Verification
The flags are the only state in the block, so a wrong flag shows up one clock edge later on the flag outputs. It also feeds into the result of the next carry-using add, subtract or rotate-through-carry. A flag written when its mode bit was clear is seen on the very next cycle. The bench keeps its own copy of the five flags and compares every output after every operation. Stale or corrupted state is therefore caught on the first cycle it becomes visible, and at the latest on the next operation that consumes it.

// File: rtl/ucode_alu.sv
module ucode_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [5:0]   alu_op,
  input  logic [7:0]   instr,
  input  logic [1:0]   psw_mode,
  input  logic         aux_as_carry,
  output logic [W-1:0] result,
  output logic         flag_cy,
  output logic         flag_ac,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_p
);

  localparam logic [5:0] OP_RLC  = 6'b000000;
  localparam logic [5:0] OP_RRC  = 6'b000001;
  localparam logic [5:0] OP_RAL  = 6'b000010;
  localparam logic [5:0] OP_RAR  = 6'b000011;
  localparam logic [5:0] OP_AND  = 6'b000100;
  localparam logic [5:0] OP_OR   = 6'b000101;
  localparam logic [5:0] OP_NOT  = 6'b000110;
  localparam logic [5:0] OP_XOR  = 6'b000111;
  localparam logic [5:0] OP_ADD  = 6'b001100;
  localparam logic [5:0] OP_ADC  = 6'b001101;
  localparam logic [5:0] OP_SUB  = 6'b001110;
  localparam logic [5:0] OP_SBB  = 6'b001111;
  localparam logic [5:0] OP_PASS = 6'b010111;
  localparam logic [5:0] OP_RST  = 6'b011111;
  localparam logic [5:0] OP_CMC  = 6'b101100;
  localparam logic [5:0] OP_SEC  = 6'b101101;
  localparam int         HW      = W / 2;

  logic           cin;
  logic [W:0]     add_full, sub_full;
  logic [HW:0]    add_half, sub_half;
  logic [W-1:0]   res;
  logic           nxt_cy, nxt_ac, op_ok;

  assign cin = (alu_op == OP_ADC || alu_op == OP_SBB) ?
               (aux_as_carry ? flag_ac : flag_cy) : 1'b0;

  assign add_full = {1'b0, src_b} + {1'b0, src_a} + {{W{1'b0}}, cin};
  assign add_half = {1'b0, src_b[HW-1:0]} + {1'b0, src_a[HW-1:0]} + {{HW{1'b0}}, cin};
  assign sub_full = {1'b0, src_b} - {1'b0, src_a} - {{W{1'b0}}, cin};
  assign sub_half = {1'b0, src_b[HW-1:0]} - {1'b0, src_a[HW-1:0]} - {{HW{1'b0}}, cin};

  always_comb begin
    res    = '0;
    nxt_cy = flag_cy;
    nxt_ac = flag_ac;
    op_ok  = 1'b1;
    case (alu_op)
      OP_ADD, OP_ADC: begin
        res    = add_full[W-1:0];
        nxt_cy = add_full[W];
        nxt_ac = add_half[HW];
      end
      OP_SUB, OP_SBB: begin
        res    = sub_full[W-1:0];
        nxt_cy = sub_full[W];
        nxt_ac = sub_half[HW];
      end
      OP_AND: begin res = src_a & src_b; nxt_cy = 1'b0; nxt_ac = 1'b0; end
      OP_OR:  begin res = src_a | src_b; nxt_cy = 1'b0; nxt_ac = 1'b0; end
      OP_NOT: begin res = ~src_a;        nxt_cy = 1'b0; nxt_ac = 1'b0; end
      OP_XOR: begin res = src_a ^ src_b; nxt_cy = 1'b0; nxt_ac = 1'b0; end
      OP_RLC: begin res = {src_a[W-2:0], src_a[W-1]}; nxt_cy = src_a[W-1]; end
      OP_RRC: begin res = {src_a[0], src_a[W-1:1]};   nxt_cy = src_a[0];   end
      OP_RAL: begin res = {src_a[W-2:0], flag_cy};    nxt_cy = src_a[W-1]; end
      OP_RAR: begin res = {flag_cy, src_a[W-1:1]};    nxt_cy = src_a[0];   end
      OP_PASS: res = src_a;
      OP_RST:  res = W'({instr[5:3], 3'b000});
      OP_CMC:  nxt_cy = ~flag_cy;
      OP_SEC:  nxt_cy = 1'b1;
      default: op_ok = 1'b0;
    endcase
  end

  assign result = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_cy <= 1'b0;
      flag_ac <= 1'b0;
      flag_z  <= 1'b0;
      flag_s  <= 1'b0;
      flag_p  <= 1'b0;
    end else if (op_ok) begin
      if (psw_mode[0]) flag_cy <= nxt_cy;
      if (psw_mode[1]) begin
        flag_ac <= nxt_ac;
        flag_z  <= (res == '0);
        flag_s  <= res[W-1];
        flag_p  <= ~^res;
      end
    end
  end

  AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    psw_mode == 2'b00 |=> $stable({flag_cy, flag_ac, flag_z, flag_s, flag_p})); // R8
  AST_CY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    psw_mode == 2'b01 |=> $stable({flag_ac, flag_z, flag_s, flag_p})); // R8
  AST_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
    psw_mode == 2'b10 |=> $stable(flag_cy)); // R8
  AST_SET_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == OP_SEC && psw_mode[0]) |=> flag_cy); // R7
  AST_CMC_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == OP_CMC && psw_mode[0]) |=> flag_cy != $past(flag_cy)); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ok && psw_mode[1]) |=> flag_z == ($past(result) == '0)); // R9
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ok |=> $stable({flag_cy, flag_ac, flag_z, flag_s, flag_p})); // R11

endmodule

// File: tb/ucode_alu_tb.sv
module ucode_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_a = '0, src_b = '0, instr = '0;
  logic [5:0] alu_op = 6'b111111;
  logic [1:0] psw_mode = '0;
  logic       aux_as_carry = 1'b0;
  logic [7:0] result;
  logic       flag_cy, flag_ac, flag_z, flag_s, flag_p;

  int checks = 0, errors = 0;
  bit done = 0;
  logic e_cy = 0, e_ac = 0, e_z = 0, e_s = 0, e_p = 0;

  always #4 clk = ~clk;

  ucode_alu u_dut (.clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .alu_op(alu_op), .instr(instr), .psw_mode(psw_mode), .aux_as_carry(aux_as_carry),
    .result(result), .flag_cy(flag_cy), .flag_ac(flag_ac), .flag_z(flag_z),
    .flag_s(flag_s), .flag_p(flag_p));

  function automatic logic [10:0] ref_alu(input logic [5:0] op, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] ir, input logic cy, input logic ac, input logic aux);
    int r, c, ci;
    logic ncy, nac, ok;
    ncy = cy; nac = ac; ok = 1; r = 0;
    ci = aux ? int'(ac) : int'(cy);
    case (op)
      6'b001100, 6'b001101: begin
        c = (op == 6'b001101) ? ci : 0;
        r = int'(b) + int'(a) + c;
        ncy = r > 255; nac = (int'(b % 16) + int'(a % 16) + c) > 15; r = r % 256;
      end
      6'b001110, 6'b001111: begin
        c = (op == 6'b001111) ? ci : 0;
        ncy = (int'(a) + c) > int'(b);
        nac = (int'(a % 16) + c) > int'(b % 16);
        r = (int'(b) - int'(a) - c + 512) % 256;
      end
      6'b000100: begin r = int'(a & b); ncy = 0; nac = 0; end
      6'b000101: begin r = int'(a | b); ncy = 0; nac = 0; end
      6'b000110: begin r = 255 - int'(a); ncy = 0; nac = 0; end
      6'b000111: begin r = int'(a ^ b); ncy = 0; nac = 0; end
      6'b000000: begin r = (int'(a) * 2) % 256 + int'(a[7]); ncy = a[7]; end
      6'b000001: begin r = int'(a) / 2 + 128 * int'(a[0]); ncy = a[0]; end
      6'b000010: begin r = (int'(a) * 2) % 256 + int'(cy); ncy = a[7]; end
      6'b000011: begin r = int'(a) / 2 + 128 * int'(cy); ncy = a[0]; end
      6'b010111: r = int'(a);
      6'b011111: r = 8 * int'(ir[5:3]);
      6'b101100: ncy = ~cy;
      6'b101101: ncy = 1'b1;
      default: ok = 0;
    endcase
    return {ok, r[7:0], ncy, nac};
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [5:0] op, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] ir, input logic [1:0] mode, input logic aux);
    logic [10:0] m;
    logic [7:0] r;
    @(negedge clk);
    alu_op = op; src_a = a; src_b = b; instr = ir; psw_mode = mode; aux_as_carry = aux;
    m = ref_alu(op, a, b, ir, e_cy, e_ac, aux);
    r = m[9:2];
    #2;
    check(req, "result", result, r);
    if (m[10]) begin
      if (mode[0]) e_cy = m[1];
      if (mode[1]) begin
        e_ac = m[0]; e_z = (r == 0); e_s = r[7]; e_p = ~^r;
      end
    end
    @(posedge clk); #2;
    check(req, "flags{cy,ac,z,s,p}", {3'b0, flag_cy, flag_ac, flag_z, flag_s, flag_p},
          {3'b0, e_cy, e_ac, e_z, e_s, e_p});
  endtask

  localparam logic [5:0] OPS [16] = '{6'b000000, 6'b000001, 6'b000010, 6'b000011,
    6'b000100, 6'b000101, 6'b000110, 6'b000111, 6'b001100, 6'b001101, 6'b001110,
    6'b001111, 6'b010111, 6'b011111, 6'b101100, 6'b101101};

  initial begin
    void'($urandom(32'h5eed_1234));
    #10;
    checks++;
    if ({flag_cy, flag_ac, flag_z, flag_s, flag_p} !== 5'b0) begin
      errors++; $display("FAIL R1 reset flags: actual %05b expected 00000", {flag_cy, flag_ac, flag_z, flag_s, flag_p});
    end
    @(negedge clk); rst_n = 1'b1;
    step("R1", 6'b010111, 8'h00, 8'h00, 8'h00, 2'b00, 0);
    step("R2", 6'b001100, 8'h01, 8'h0F, 8'h00, 2'b11, 0);
    step("R2", 6'b001100, 8'h01, 8'hFF, 8'h00, 2'b11, 0);
    step("R2", 6'b001101, 8'h10, 8'h20, 8'h00, 2'b11, 0);
    step("R3", 6'b001110, 8'h01, 8'h00, 8'h00, 2'b11, 0);
    step("R3", 6'b001111, 8'h05, 8'h05, 8'h00, 2'b11, 0);
    step("R4", 6'b000110, 8'hA5, 8'h00, 8'h00, 2'b11, 0);
    step("R5", 6'b000010, 8'h80, 8'h00, 8'h00, 2'b01, 0);
    step("R5", 6'b000011, 8'h01, 8'h00, 8'h00, 2'b11, 0);
    step("R6", 6'b011111, 8'h00, 8'h00, 8'hFF, 2'b11, 0);
    step("R7", 6'b101101, 8'h33, 8'h44, 8'h00, 2'b01, 0);
    step("R7", 6'b101100, 8'h00, 8'h00, 8'h00, 2'b01, 0);
    step("R8", 6'b001100, 8'hFF, 8'hFF, 8'h00, 2'b10, 0);
    step("R8", 6'b001100, 8'hFF, 8'hFF, 8'h00, 2'b00, 0);
    step("R9", 6'b000111, 8'h3C, 8'h3D, 8'h00, 2'b11, 0);
    step("R10", 6'b001100, 8'h08, 8'h08, 8'h00, 2'b11, 0);
    step("R10", 6'b001101, 8'h00, 8'h00, 8'h00, 2'b11, 1);
    step("R10", 6'b001111, 8'h00, 8'h00, 8'h00, 2'b11, 1);
    step("R11", 6'b111111, 8'h55, 8'h66, 8'h00, 2'b11, 0);
    step("R11", 6'b101110, 8'h00, 8'h00, 8'h00, 2'b11, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      op = ($urandom % 8 == 0) ? 6'($urandom) : OPS[$urandom % 16];
      step("R2-R11 random", op, 8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule